// File: doc/BRIEF.md
# Load/Store Address and Part-Word Unit

This block sits between the register read stage and a word-addressed 32-bit data memory. For each memory operation it computes the effective byte address from a base register plus either a sign-extended 16-bit immediate or a register-sourced offset. It can also use a zero-extended absolute address instead. It produces the word address and the byte-lane enables for the memory port. For stores it places the least significant byte or halfword of the source register on every lane the access can hit.

Two mode bits choose the addressing mode. The pre bit decides whether the address is the plain base or base plus offset. The update bit decides whether base plus offset is written back to the base register. Load data returns from memory one cycle after the request. In that cycle the block selects the addressed byte or halfword, sign- or zero-extends it, and presents it with the destination index.

The block also watches the instruction being issued in that return cycle. If that instruction reads the register being loaded, it raises a one-cycle stall. While the stall is high, any memory operation presented to the block is not accepted.

Top module: `ldst_unit`

## Requirements
- R1: With `op_pre`=0 the byte address is the base. With `op_pre`=1 it is base plus offset. `mem_waddr` carries byte address bits [31:2].
- R2: With `op_upd`=1 on a non-absolute operation, `wb_base_en` is high and `wb_base` equals base plus offset, whatever `op_pre` is. With `op_upd`=0, `wb_base_en` is low.
- R3: When `op_reg_off`=0 the offset is `op_imm` sign-extended from 16 bits. When `op_reg_off`=1 the offset is the full 32-bit `op_roff`.
- R4: With `op_abs`=1 the address is `op_absaddr` zero-extended from 21 bits with its two low bits cleared. The access is a full word regardless of size code or mode bits, and no base write-back occurs.
- R5: Size code `op_size` is 2'b01 for word, 2'b00 for halfword and 2'b10 for byte; 2'b11 is treated as word. A word access ignores address bits [1:0] and a halfword access ignores address bit 0.
- R6: `mem_be` bit k enables byte lane k, which is data bits [8k+7:8k] (little-endian). A byte access enables only the lane given by address bits [1:0]. A halfword access enables lanes 1:0 when address bit 1 is 0 and lanes 3:2 when it is 1. A word access enables all four lanes.
- R7: Store data `mem_wdata` is the source replicated to all lanes: a byte store repeats `op_sdata`[7:0] four times, a halfword store repeats `op_sdata`[15:0] twice, and a word store passes `op_sdata` unchanged. `mem_we` is high only for accepted stores.
- R8: One cycle after an accepted load, `ld_valid` is high and `ld_idx` equals that load's `op_dst`. An accepted store produces no `ld_valid`.
- R9: The returned value is the addressed byte or halfword of `mem_rdata` placed in the low bits. The upper bits are zero when `op_zext`=1 and copies of the part-word sign bit when `op_zext`=0. A word load returns `mem_rdata` unchanged.
- R10: `stall` is high exactly when `ld_valid` is high, `iss_valid` is high, and `iss_src_a` or `iss_src_b` equals `ld_idx`. It never lasts two consecutive cycles. While it is high, `mem_req`, `mem_we` and `wb_base_en` stay low and the presented operation is dropped.
- R11: Synchronous reset `rst` clears any pending load, so `ld_valid` and `stall` are low in the cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | A memory operation is presented this cycle |
| op_load | input | 1 | 1 = load, 0 = store |
| op_abs | input | 1 | Use the absolute-address form |
| op_pre | input | 1 | Address is base plus offset |
| op_upd | input | 1 | Write base plus offset back to the base register |
| op_size | input | 2 | Access size code |
| op_zext | input | 1 | Zero-extend part-word loads |
| op_reg_off | input | 1 | Offset comes from `op_roff` |
| op_base | input | 32 | Base register value |
| op_imm | input | 16 | Immediate offset |
| op_roff | input | 32 | Register-sourced offset |
| op_absaddr | input | 21 | Absolute address |
| op_sdata | input | 32 | Store source register value |
| op_dst | input | 5 | Load destination register index |
| iss_valid | input | 1 | An instruction is being issued this cycle |
| iss_src_a | input | 5 | First source register index of issued instruction |
| iss_src_b | input | 5 | Second source register index of issued instruction |
| mem_rdata | input | 32 | Read data, valid the cycle after a load request |
| mem_req | output | 1 | Memory access accepted this cycle |
| mem_we | output | 1 | Access is a write |
| mem_waddr | output | 30 | Word address |
| mem_be | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Lane-replicated write data |
| wb_base_en | output | 1 | Base register write-back strobe |
| wb_base | output | 32 | Updated base value |
| ld_valid | output | 1 | Load result valid |
| ld_idx | output | 5 | Destination index of the load result |
| ld_data | output | 32 | Extended load result |
| stall | output | 1 | Hold the issued instruction one cycle |

## Verification
Some properties are checked on every cycle. The stall is at most one cycle long, only follows a pending load, and suppresses every memory and write-back strobe. Every accepted load is answered one cycle later with its own index, and stores never are. Absolute-form accesses are full-word with no write-back, and byte accesses enable a single lane. Zero-extended byte loads leave the upper 24 bits clear. The exact arithmetic cannot be shown by these properties: the address sums with negative offsets, lane selection from the low address bits, replication patterns, sign extension of returned data, and stall matching on each source port. Those are shown only by the bench's vector table and directed stall and reset scenarios.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

    localparam int unsigned WORD_W     = 32;
    localparam int unsigned LANES      = WORD_W / 8;
    localparam int unsigned LANE_IDX_W = $clog2(LANES);

    // encoded size field as it appears on op_size
    typedef enum logic [1:0] {
        SZ_HALF = 2'b00,
        SZ_WORD = 2'b01,
        SZ_BYTE = 2'b10,
        SZ_RSVD = 2'b11
    } size_e;

    // normalized access width used by the datapath
    typedef enum logic [1:0] {
        ACC_BYTE = 2'd0,
        ACC_HALF = 2'd1,
        ACC_WORD = 2'd2
    } acc_e;

    // context held across the one-cycle load return
    typedef struct packed {
        logic [LANE_IDX_W-1:0] lane;
        acc_e                  acc;
        logic                  zext;
    } ld_ctx_t;

    function automatic acc_e norm_size(input logic [1:0] code, input logic abs_mode);
        acc_e r;
        if (abs_mode) begin
            r = ACC_WORD;
        end else begin
            case (code)
                SZ_BYTE: r = ACC_BYTE;
                SZ_HALF: r = ACC_HALF;
                default: r = ACC_WORD;
            endcase
        end
        return r;
    endfunction

    function automatic logic [WORD_W-1:0] align_addr(input logic [WORD_W-1:0] a, input acc_e acc);
        logic [WORD_W-1:0] r;
        r = a;
        case (acc)
            ACC_HALF: r[0] = 1'b0;
            ACC_WORD: r[LANE_IDX_W-1:0] = '0;
            default:  r = a;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ldst_addr_gen.sv
module ldst_addr_gen
    import ldst_pkg::*;
#(
    parameter int unsigned OFF_W = 16,
    parameter int unsigned ABS_W = 21
) (
    input  logic [WORD_W-1:0] base,
    input  logic [OFF_W-1:0]  imm,
    input  logic              use_roff,
    input  logic [WORD_W-1:0] roff,
    input  logic              pre,
    input  logic              upd,
    input  logic              abs_mode,
    input  logic [ABS_W-1:0]  abs_addr,
    input  logic [1:0]        size_code,
    output logic [WORD_W-1:0] ea,
    output acc_e              acc,
    output logic              wb_req,
    output logic [WORD_W-1:0] wb_value
);
    localparam int unsigned SEXT_W = WORD_W - OFF_W;
    localparam int unsigned ZEXT_W = WORD_W - ABS_W;

    logic [WORD_W-1:0] offset;
    logic [WORD_W-1:0] sum;
    logic [WORD_W-1:0] abs_ea;
    logic [WORD_W-1:0] raw_ea;

    always_comb begin
        offset   = use_roff ? roff : {{SEXT_W{imm[OFF_W-1]}}, imm};
        sum      = base + offset;
        abs_ea   = {{ZEXT_W{1'b0}}, abs_addr[ABS_W-1:2], 2'b00};
        raw_ea   = abs_mode ? abs_ea : (pre ? sum : base);
        acc      = norm_size(size_code, abs_mode);
        ea       = align_addr(raw_ea, acc);
        wb_req   = upd & ~abs_mode;
        wb_value = sum;
    end

endmodule

// File: rtl/ldst_store_lanes.sv
module ldst_store_lanes
    import ldst_pkg::*;
(
    input  acc_e                  acc,
    input  logic [LANE_IDX_W-1:0] lane,
    input  logic [WORD_W-1:0]     src,
    output logic [LANES-1:0]      be,
    output logic [WORD_W-1:0]     wdata
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam logic [LANE_IDX_W-1:0] LIDX = LANE_IDX_W'(g);
        always_comb begin
            case (acc)
                ACC_BYTE: begin
                    be[g]          = (lane == LIDX);
                    wdata[8*g +: 8] = src[7:0];
                end
                ACC_HALF: begin
                    be[g]          = (lane[LANE_IDX_W-1:1] == LIDX[LANE_IDX_W-1:1]);
                    wdata[8*g +: 8] = src[8*(g%2) +: 8];
                end
                default: begin
                    be[g]          = 1'b1;
                    wdata[8*g +: 8] = src[8*g +: 8];
                end
            endcase
        end
    end

endmodule

// File: rtl/ldst_load_extract.sv
module ldst_load_extract
    import ldst_pkg::*;
(
    input  ld_ctx_t           ctx,
    input  logic [WORD_W-1:0] rdata,
    output logic [WORD_W-1:0] result
);
    logic [7:0]  byte_sel;
    logic [15:0] half_sel;

    always_comb begin
        byte_sel = rdata[8*ctx.lane +: 8];
        half_sel = rdata[16*ctx.lane[LANE_IDX_W-1:1] +: 16];
        case (ctx.acc)
            ACC_BYTE: result = {{(WORD_W-8){byte_sel[7] & ~ctx.zext}}, byte_sel};
            ACC_HALF: result = {{(WORD_W-16){half_sel[15] & ~ctx.zext}}, half_sel};
            default:  result = rdata;
        endcase
    end

endmodule

// File: rtl/ldst_unit.sv
module ldst_unit
    import ldst_pkg::*;
#(
    parameter int unsigned OFF_W  = 16,
    parameter int unsigned ABS_W  = 21,
    parameter int unsigned RIDX_W = 5
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     op_valid,
    input  logic                     op_load,
    input  logic                     op_abs,
    input  logic                     op_pre,
    input  logic                     op_upd,
    input  logic [1:0]               op_size,
    input  logic                     op_zext,
    input  logic                     op_reg_off,
    input  logic [WORD_W-1:0]        op_base,
    input  logic [OFF_W-1:0]         op_imm,
    input  logic [WORD_W-1:0]        op_roff,
    input  logic [ABS_W-1:0]         op_absaddr,
    input  logic [WORD_W-1:0]        op_sdata,
    input  logic [RIDX_W-1:0]        op_dst,
    input  logic                     iss_valid,
    input  logic [RIDX_W-1:0]        iss_src_a,
    input  logic [RIDX_W-1:0]        iss_src_b,
    input  logic [WORD_W-1:0]        mem_rdata,
    output logic                     mem_req,
    output logic                     mem_we,
    output logic [WORD_W-LANE_IDX_W-1:0] mem_waddr,
    output logic [LANES-1:0]         mem_be,
    output logic [WORD_W-1:0]        mem_wdata,
    output logic                     wb_base_en,
    output logic [WORD_W-1:0]        wb_base,
    output logic                     ld_valid,
    output logic [RIDX_W-1:0]        ld_idx,
    output logic [WORD_W-1:0]        ld_data,
    output logic                     stall
);
    logic [WORD_W-1:0] ea;
    acc_e              acc;
    logic              wb_req;
    logic [LANES-1:0]  lane_be;
    logic              accept;
    logic              pend_q;
    logic [RIDX_W-1:0] idx_q;
    ld_ctx_t           ctx_q;

    ldst_addr_gen #(.OFF_W(OFF_W), .ABS_W(ABS_W)) u_agen (
        .base      (op_base),
        .imm       (op_imm),
        .use_roff  (op_reg_off),
        .roff      (op_roff),
        .pre       (op_pre),
        .upd       (op_upd),
        .abs_mode  (op_abs),
        .abs_addr  (op_absaddr),
        .size_code (op_size),
        .ea        (ea),
        .acc       (acc),
        .wb_req    (wb_req),
        .wb_value  (wb_base)
    );

    ldst_store_lanes u_lanes (
        .acc   (acc),
        .lane  (ea[LANE_IDX_W-1:0]),
        .src   (op_sdata),
        .be    (lane_be),
        .wdata (mem_wdata)
    );

    ldst_load_extract u_extract (
        .ctx    (ctx_q),
        .rdata  (mem_rdata),
        .result (ld_data)
    );

    always_comb begin
        stall      = pend_q & iss_valid & ((iss_src_a == idx_q) | (iss_src_b == idx_q));
        accept     = op_valid & ~stall;
        mem_req    = accept;
        mem_we     = accept & ~op_load;
        mem_waddr  = ea[WORD_W-1:LANE_IDX_W];
        mem_be     = accept ? lane_be : '0;
        wb_base_en = accept & wb_req;
        ld_valid   = pend_q;
        ld_idx     = idx_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            idx_q  <= '0;
            ctx_q  <= '0;
        end else begin
            pend_q <= accept & op_load;
            if (accept & op_load) begin
                idx_q      <= op_dst;
                ctx_q.lane <= ea[LANE_IDX_W-1:0];
                ctx_q.acc  <= acc;
                ctx_q.zext <= op_zext;
            end
        end
    end

endmodule

// File: rtl/ldst_unit_chk.sv
module ldst_unit_chk
    import ldst_pkg::*;
#(
    parameter int unsigned RIDX_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              op_abs,
    input logic              op_zext,
    input logic [1:0]        op_size,
    input logic [RIDX_W-1:0] op_dst,
    input logic              mem_req,
    input logic              mem_we,
    input logic [LANES-1:0]  mem_be,
    input logic              wb_base_en,
    input logic              ld_valid,
    input logic [RIDX_W-1:0] ld_idx,
    input logic [WORD_W-1:0] ld_data,
    input logic              stall
);
    a_r10_stall_single: assert property (@(posedge clk) disable iff (rst)
        stall |=> !stall);

    a_r10_stall_blocks: assert property (@(posedge clk) disable iff (rst)
        stall |-> (!mem_req && !mem_we && !wb_base_en));

    a_r10_stall_after_load: assert property (@(posedge clk) disable iff (rst)
        stall |-> ld_valid);

    a_r8_load_returns: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |=> (ld_valid && ld_idx == $past(op_dst)));

    a_r8_store_silent: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |=> !ld_valid);

    a_r4_abs_full_word: assert property (@(posedge clk) disable iff (rst)
        (mem_req && op_abs) |-> (mem_be == {LANES{1'b1}} && !wb_base_en));

    a_r6_byte_one_lane: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !op_abs && op_size == SZ_BYTE) |-> $countones(mem_be) == 1);

    a_r9_zext_byte: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we && !op_abs && op_size == SZ_BYTE && op_zext)
            |=> ld_data[WORD_W-1:8] == '0);

    a_r11_reset_clears: assert property (@(posedge clk)
        rst |=> (!ld_valid && !stall));

endmodule

bind ldst_unit ldst_unit_chk #(.RIDX_W(RIDX_W)) u_chk (.*);

// File: tb/ldst_unit_test.sv
`timescale 1ns/1ps
module ldst_unit_test;

    typedef struct packed {
        logic        ld;
        logic        ab;
        logic        p;
        logic        q;
        logic [1:0]  sz;
        logic        zx;
        logic        ur;
        logic [31:0] base;
        logic [15:0] off;
        logic [31:0] roff;
        logic [20:0] absa;
        logic [31:0] sd;
        logic [31:0] rd;
        logic [29:0] x_wa;
        logic [3:0]  x_be;
        logic        x_wbe;
        logic [31:0] x_wb;
        logic [31:0] x_dat;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        // 0: R1 plain base, word store
        '{0,0,0,0,2'b01,0,0,32'h1000,16'h0010,32'h0,21'h0,32'hA1B2C3D4,32'h0,30'h400,4'hF,0,32'h0,32'hA1B2C3D4},
        // 1: R6 R7 byte store lane 3
        '{0,0,1,0,2'b10,0,0,32'h2000,16'h0003,32'h0,21'h0,32'h0000005A,32'h0,30'h800,4'h8,0,32'h0,32'h5A5A5A5A},
        // 2: R2 R3 negative immediate, pre + update, upper half
        '{0,0,1,1,2'b00,0,0,32'h3000,16'hFFFE,32'h0,21'h0,32'h1234BEEF,32'h0,30'hBFF,4'hC,1,32'h2FFE,32'hBEEFBEEF},
        // 3: R5 misaligned halfword forced down
        '{0,0,1,0,2'b00,0,0,32'h100,16'h0001,32'h0,21'h0,32'hCAFE0077,32'h0,30'h40,4'h3,0,32'h0,32'h00770077},
        // 4: R2 post-update: address is base, write-back base+offset
        '{1,0,0,1,2'b01,0,0,32'h4000,16'h0008,32'h0,21'h0,32'h0,32'h89ABCDEF,30'h1000,4'hF,1,32'h4008,32'h89ABCDEF},
        // 5: R9 signed byte load lane 2
        '{1,0,1,0,2'b10,0,0,32'h5000,16'h0002,32'h0,21'h0,32'h0,32'h11F02233,30'h1400,4'h4,0,32'h0,32'hFFFFFFF0},
        // 6: R9 zero-extended byte load lane 2
        '{1,0,1,0,2'b10,1,0,32'h5000,16'h0002,32'h0,21'h0,32'h0,32'h11F02233,30'h1400,4'h4,0,32'h0,32'h000000F0},
        // 7: R9 signed half load upper pair
        '{1,0,1,0,2'b00,0,0,32'h6000,16'h0002,32'h0,21'h0,32'h0,32'h80017FFF,30'h1800,4'hC,0,32'h0,32'hFFFF8001},
        // 8: R9 zero-extended half load lower pair
        '{1,0,1,0,2'b00,1,0,32'h6000,16'h0000,32'h0,21'h0,32'h0,32'h12349ABC,30'h1800,4'h3,0,32'h0,32'h00009ABC},
        // 9: R3 register offset, byte lane 1 signed
        '{1,0,1,1,2'b10,0,1,32'h7000,16'hFFFF,32'h5,21'h0,32'h0,32'hAABB80CC,30'h1C01,4'h2,1,32'h7005,32'hFFFFFF80},
        // 10: R4 absolute, low bits dropped, byte code ignored
        '{1,1,1,1,2'b10,0,0,32'hFFFF0000,16'h0,32'h0,21'h1FFFFF,32'h0,32'h01020304,30'h7FFFF,4'hF,0,32'h0,32'h01020304},
        // 11: R5 reserved size code acts as word
        '{0,0,0,0,2'b11,0,0,32'h8002,16'h0,32'h0,21'h0,32'h0BADF00D,32'h0,30'h2000,4'hF,0,32'h0,32'h0BADF00D},
        // 12: R3 most negative immediate
        '{0,0,1,1,2'b01,0,0,32'h10,16'h8000,32'h0,21'h0,32'h55AA55AA,32'h0,30'h3FFFE004,4'hF,1,32'hFFFF8010,32'h55AA55AA}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid, op_load, op_abs, op_pre, op_upd, op_zext, op_reg_off;
    logic [1:0]  op_size;
    logic [31:0] op_base, op_roff, op_sdata;
    logic [15:0] op_imm;
    logic [20:0] op_absaddr;
    logic [4:0]  op_dst, iss_src_a, iss_src_b;
    logic        iss_valid;
    logic [31:0] mem_rdata;
    logic        mem_req, mem_we, wb_base_en, ld_valid, stall;
    logic [29:0] mem_waddr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata, wb_base, ld_data;
    logic [4:0]  ld_idx;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    ldst_unit uut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input vec_t v, input logic [4:0] dst);
        op_valid   = 1'b1;
        op_load    = v.ld;
        op_abs     = v.ab;
        op_pre     = v.p;
        op_upd     = v.q;
        op_size    = v.sz;
        op_zext    = v.zx;
        op_reg_off = v.ur;
        op_base    = v.base;
        op_imm     = v.off;
        op_roff    = v.roff;
        op_absaddr = v.absa;
        op_sdata   = v.sd;
        op_dst     = dst;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        op_valid = 0; op_load = 0; op_abs = 0; op_pre = 0; op_upd = 0;
        op_zext = 0; op_reg_off = 0; op_size = 2'b01;
        op_base = 0; op_roff = 0; op_sdata = 0; op_imm = 0; op_absaddr = 0; op_dst = 0;
        iss_valid = 0; iss_src_a = 0; iss_src_b = 0; mem_rdata = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R11 reset state
        chk("R11 ld_valid after reset", 32'(ld_valid), 32'd0);
        chk("R11 stall after reset", 32'(stall), 32'd0);
        chk("R11 mem_req idle", 32'(mem_req), 32'd0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            apply(VECS[i], 5'(i));
            iss_valid = 1'b0;
            #1;
            chk($sformatf("R1/R5 vec%0d word address", i), 32'(mem_waddr), 32'(VECS[i].x_wa));
            chk($sformatf("R6 vec%0d lane enables", i), 32'(mem_be), 32'(VECS[i].x_be));
            chk($sformatf("R2 vec%0d write-back strobe", i), 32'(wb_base_en), 32'(VECS[i].x_wbe));
            if (VECS[i].x_wbe)
                chk($sformatf("R2 vec%0d write-back value", i), wb_base, VECS[i].x_wb);
            chk($sformatf("R7 vec%0d write enable", i), 32'(mem_we), 32'(!VECS[i].ld));
            if (!VECS[i].ld)
                chk($sformatf("R7 vec%0d store data", i), mem_wdata, VECS[i].x_dat);
            @(negedge clk);
            op_valid  = 1'b0;
            mem_rdata = VECS[i].rd;
            #1;
            chk($sformatf("R8 vec%0d ld_valid", i), 32'(ld_valid), 32'(VECS[i].ld));
            if (VECS[i].ld) begin
                chk($sformatf("R8 vec%0d ld_idx", i), 32'(ld_idx), 32'(i));
                chk($sformatf("R9 vec%0d load data", i), ld_data, VECS[i].x_dat);
            end
        end

        // R10: source A hit, and the operation presented during the stall is dropped
        op_abs = 0; op_pre = 1; op_upd = 1; op_size = 2'b01;
        @(negedge clk);
        op_valid = 1; op_load = 1; op_dst = 5'd7;
        @(negedge clk);
        iss_valid = 1; iss_src_a = 5'd7; iss_src_b = 5'd0;
        op_valid = 1; op_load = 1; op_dst = 5'd9;
        #1;
        chk("R10 stall on src_a match", 32'(stall), 32'd1);
        chk("R10 no mem_req during stall", 32'(mem_req), 32'd0);
        chk("R10 no write-back during stall", 32'(wb_base_en), 32'd0);
        @(negedge clk);
        op_valid = 0;
        #1;
        chk("R10 stall lasts one cycle", 32'(stall), 32'd0);
        chk("R10 dropped load gives no result", 32'(ld_valid), 32'd0);

        // R10: source B hit
        @(negedge clk);
        iss_valid = 0; op_valid = 1; op_load = 1; op_dst = 5'd12;
        @(negedge clk);
        op_valid = 0; iss_valid = 1; iss_src_a = 5'd3; iss_src_b = 5'd12;
        #1;
        chk("R10 stall on src_b match", 32'(stall), 32'd1);

        // R10: no match
        @(negedge clk);
        iss_valid = 0; op_valid = 1; op_load = 1; op_dst = 5'd4;
        @(negedge clk);
        op_valid = 0; iss_valid = 1; iss_src_a = 5'd3; iss_src_b = 5'd5;
        #1;
        chk("R10 no stall without match", 32'(stall), 32'd0);

        // R10: match but issue slot empty
        @(negedge clk);
        iss_valid = 0; op_valid = 1; op_load = 1; op_dst = 5'd3;
        @(negedge clk);
        op_valid = 0; iss_valid = 0;
        #1;
        chk("R10 no stall when nothing issues", 32'(stall), 32'd0);

        // R10: stores never cause a stall
        @(negedge clk);
        op_valid = 1; op_load = 0; op_dst = 5'd6;
        @(negedge clk);
        op_valid = 0; iss_valid = 1; iss_src_a = 5'd6; iss_src_b = 5'd6;
        #1;
        chk("R10 no stall after store", 32'(stall), 32'd0);

        // R11: reset during a pending load
        @(negedge clk);
        iss_valid = 0; op_valid = 1; op_load = 1; op_dst = 5'd2;
        rst = 1'b1;
        @(negedge clk);
        op_valid = 0; iss_valid = 1; iss_src_a = 5'd2;
        #1;
        chk("R11 reset drops pending load", 32'(ld_valid), 32'd0);
        chk("R11 reset drops stall", 32'(stall), 32'd0);
        rst = 1'b0;
        iss_valid = 0;
        @(negedge clk);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule